// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block drives the raster timing for a 320x240 RGB panel whose pixels arrive over an 8-bit byte-serial bus. Every count is in bus clocks. One pixel takes two bus clocks in 16-bit mode and three in 24-bit mode. The block produces active-low horizontal and vertical sync pulses, a data-enable strobe, and the index of the current byte within its pixel. It also brings out its column and line counters, which the pixel source uses to address data.

The block starts frames by itself and repeats them for as long as the enable input is high, so no frame request is needed from a frame buffer. The format select is read only at the start of a frame. The data window in each line is offset by a fixed lead of seven pixel times plus a pipeline delay that depends on the format. When enable goes low, the block clears itself at the next clock edge and holds its outputs inactive.

Top module: `lcd_sync_gen`

## Requirements
- R1: The clocks-per-pixel factor `cpp` is 2 when `fmt_i`=0 (16-bit) and 3 when `fmt_i`=1 (24-bit). While `de_o` is high, `phase_o` counts 0,1,..,cpp-1 and repeats, starting at 0 on the first data clock of the line. While `de_o` is low, `phase_o` is 0.
- R2: `col_o` counts bus clocks from 0 to 336*cpp-1 and then returns to 0.
- R3: `hsync_no` is low exactly while `col_o` < 2*cpp, on every line, and high at all other times while running.
- R4: Within an active line, `de_o` is high exactly for the columns from 7*cpp+D up to but not including 7*cpp+D+320*cpp. D is 3 in 16-bit mode and 5 in 24-bit mode. This gives column 17 or 26 as the first data clock.
- R5: `line_o` advances when `col_o` wraps and counts V_BLANK+V_ACTIVE lines (244 by default), then returns to 0. `vsync_no` is low exactly on line 0 while `col_o` < 2*cpp.
- R6: Lines 0 to V_BLANK-1 are blanking lines, and `de_o` stays low on them. Lines V_BLANK to V_BLANK+V_ACTIVE-1 are active lines.
- R7: `fmt_i` is sampled only at the first clock edge after enable rises and at the edge where the frame wraps. A change at any other time takes effect only at the next frame start.
- R8: At any clock edge where `en_i` is low, the counters and the phase go to 0, `hsync_no` and `vsync_no` go high and `de_o` goes low. The first enabled edge after that starts a frame at column 0, line 0.
- R9: While `rst_ni` is low, `hsync_no` and `vsync_no` are high, `de_o` is low and the counters and phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte-bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the raster |
| fmt_i | input | 1 | Pixel format: 0 = 16-bit, 1 = 24-bit |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data-enable strobe |
| phase_o | output | PH_W | Byte index within the current pixel |
| line_o | output | LINE_W | Line counter |
| col_o | output | COL_W | Column counter in bus clocks |

## Verification
The bench compares every output on every clock against a position model built from the requirements, for a full frame in each format. This catches an off-by-one in the data-window start (a design that drops the pipeline delay starts three or five clocks early) and a line length that ignores `cpp`, which shows up as the column wrapping too soon. A format switch in the middle of a frame must leave the rest of that frame on the old timing; a design that samples the format continuously would shorten the lines in progress. Dropping enable in the middle of a line must clear everything on the next edge; a design that finishes the line first, or leaves the sync low, is caught there.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int CPP_16     = 2;
  localparam int CPP_24     = 3;
  localparam int DLY_16     = 3;
  localparam int DLY_24     = 5;
  localparam int H_ACT_PIX  = 320;
  localparam int H_TOT_PIX  = 336;
  localparam int H_SYNC_PIX = 2;
  localparam int H_LEAD_PIX = 7;
  localparam int CPP_MAX    = (CPP_24 > CPP_16) ? CPP_24 : CPP_16;
  localparam int COL_W      = $clog2(H_TOT_PIX * CPP_MAX);
  localparam int PH_W       = $clog2(CPP_MAX);

  typedef enum logic {
    FMT_RGB16 = 1'b0,
    FMT_RGB24 = 1'b1
  } pix_fmt_e;

  typedef struct packed {
    logic [PH_W-1:0]  cpp;
    logic [COL_W-1:0] h_total;
    logic [COL_W-1:0] h_sync;
    logic [COL_W-1:0] h_start;
    logic [COL_W-1:0] h_end;
  } line_timing_t;

  function automatic line_timing_t timing_of(pix_fmt_e f);
    line_timing_t t;
    int cpp, dly;
    cpp       = (f == FMT_RGB24) ? CPP_24 : CPP_16;
    dly       = (f == FMT_RGB24) ? DLY_24 : DLY_16;
    t.cpp     = PH_W'(cpp);
    t.h_total = COL_W'(H_TOT_PIX * cpp);
    t.h_sync  = COL_W'(H_SYNC_PIX * cpp);
    t.h_start = COL_W'(H_LEAD_PIX * cpp + dly);
    t.h_end   = COL_W'(H_LEAD_PIX * cpp + dly + H_ACT_PIX * cpp);
    return t;
  endfunction
endpackage

// File: rtl/lcd_fmt_latch.sv
module lcd_fmt_latch
  import lcd_sync_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         fmt_i,
  output line_timing_t tim_o
);
  pix_fmt_e     fmt_q;
  line_timing_t tim_tab [2];

  for (genvar g = 0; g < 2; g++) begin : g_tab
    assign tim_tab[g] = timing_of(pix_fmt_e'(g[0]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fmt_q <= FMT_RGB16;
    else if (load_i) fmt_q <= pix_fmt_e'(fmt_i);
  end

  assign tim_o = tim_tab[fmt_q];

  AST_FMT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(fmt_q)); // R7
endmodule

// File: rtl/lcd_raster_cnt.sv
module lcd_raster_cnt
  import lcd_sync_pkg::*;
#(
  parameter int V_LINES = 244,
  parameter int LINE_W  = $clog2(V_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  line_timing_t      tim_i,
  output logic [COL_W-1:0]  col_o,
  output logic [LINE_W-1:0] line_o,
  output logic              run_o,
  output logic              load_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(V_LINES - 1);

  logic [COL_W-1:0]  col_q;
  logic [LINE_W-1:0] line_q;
  logic              run_q;
  logic              col_end;

  assign col_end = (col_q == tim_i.h_total - 1'b1);
  assign load_o  = en_i && (!run_q || (col_end && line_q == LAST_LINE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      line_q <= '0;
      run_q  <= 1'b0;
    end else if (!en_i) begin
      col_q  <= '0;
      line_q <= '0;
      run_q  <= 1'b0;
    end else if (load_o) begin
      col_q  <= '0;
      line_q <= '0;
      run_q  <= 1'b1;
    end else if (col_end) begin
      col_q  <= '0;
      line_q <= line_q + 1'b1;
    end else begin
      col_q  <= col_q + 1'b1;
    end
  end

  assign col_o  = col_q;
  assign line_o = line_q;
  assign run_o  = run_q;

  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> col_q < tim_i.h_total); // R2
  AST_DISABLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (col_q == '0 && line_q == '0 && !run_q)); // R8
  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && col_end && line_q != LAST_LINE) |=> line_q == $past(line_q) + 1'b1); // R5
endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode
  import lcd_sync_pkg::*;
#(
  parameter int V_BLANK = 4,
  parameter int LINE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              run_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [LINE_W-1:0] line_i,
  input  line_timing_t      tim_i,
  output logic              hsync_no,
  output logic              vsync_no,
  output logic              de_o,
  output logic [PH_W-1:0]   phase_o
);
  logic            in_hs, in_act, de;
  logic [PH_W-1:0] phase_q;

  assign in_hs  = run_i && (col_i < tim_i.h_sync);
  assign in_act = line_i >= LINE_W'(V_BLANK);
  assign de     = run_i && in_act && (col_i >= tim_i.h_start) && (col_i < tim_i.h_end);

  // phase follows the data window; the window length is a whole number of pixels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          phase_q <= '0;
    else if (!en_i || !de)                phase_q <= '0;
    else if (phase_q == tim_i.cpp - 1'b1) phase_q <= '0;
    else                                  phase_q <= phase_q + 1'b1;
  end

  assign hsync_no = !in_hs;
  assign vsync_no = !(in_hs && line_i == '0);
  assign de_o     = de;
  assign phase_o  = phase_q;

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < tim_i.cpp); // R1
  AST_SYNC_NOT_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_no |-> !de_o); // R4
  AST_VS_IN_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_no |-> !hsync_no); // R5
  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |=> (phase_q == '0)); // R1
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int V_ACTIVE = 240,
  parameter int V_BLANK  = 4,
  localparam int V_LINES = V_ACTIVE + V_BLANK,
  localparam int LINE_W  = $clog2(V_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fmt_i,
  output logic              hsync_no,
  output logic              vsync_no,
  output logic              de_o,
  output logic [PH_W-1:0]   phase_o,
  output logic [LINE_W-1:0] line_o,
  output logic [COL_W-1:0]  col_o
);
  line_timing_t      tim;
  logic              load, run;
  logic [COL_W-1:0]  col;
  logic [LINE_W-1:0] line;

  lcd_fmt_latch u_fmt (
    .clk_i, .rst_ni, .load_i(load), .fmt_i, .tim_o(tim)
  );

  lcd_raster_cnt #(.V_LINES(V_LINES), .LINE_W(LINE_W)) u_cnt (
    .clk_i, .rst_ni, .en_i, .tim_i(tim),
    .col_o(col), .line_o(line), .run_o(run), .load_o(load)
  );

  lcd_sync_decode #(.V_BLANK(V_BLANK), .LINE_W(LINE_W)) u_dec (
    .clk_i, .rst_ni, .en_i, .run_i(run), .col_i(col), .line_i(line),
    .tim_i(tim), .hsync_no, .vsync_no, .de_o, .phase_o
  );

  assign col_o  = col;
  assign line_o = line;
endmodule

// File: tb/tb_lcd_sync_gen.sv
`timescale 1ns/1ps
module tb_lcd_sync_gen;
  localparam int VA = 6;
  localparam int VB = 4;
  localparam int VL = VA + VB;
  localparam int LW = $clog2(VL);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fmt = 1'b0;
  logic hs_n, vs_n, de;
  logic [1:0]  ph;
  logic [LW-1:0] line;
  logic [9:0]  col;

  int n_tests = 0, n_fail = 0;
  int ec = 0, el = 0, cpp = 2;

  lcd_sync_gen #(.V_ACTIVE(VA), .V_BLANK(VB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fmt_i(fmt),
    .hsync_no(hs_n), .vsync_no(vs_n), .de_o(de), .phase_o(ph),
    .line_o(line), .col_o(col)
  );

  always #4 clk = ~clk;

  function automatic int cpp_of(logic f); return f ? 3 : 2; endfunction
  function automatic int dly_of(int c);   return (c == 3) ? 5 : 3; endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the position model; one check per category
  int e_pos, e_hs, e_vs, e_de, e_ph;
  int a_pos, x_pos, a_hs, x_hs, a_vs, x_vs, a_de, x_de, a_ph, x_ph;

  task automatic clear_errs();
    e_pos = 0; e_hs = 0; e_vs = 0; e_de = 0; e_ph = 0;
  endtask

  task automatic compare_now();
    int hst, xh, xv, xd, xp;
    hst = 7 * cpp + dly_of(cpp);
    xh  = (ec < 2 * cpp) ? 0 : 1;
    xv  = (el == 0 && ec < 2 * cpp) ? 0 : 1;
    xd  = (el >= VB && ec >= hst && ec < hst + 320 * cpp) ? 1 : 0;
    xp  = xd ? (ec - hst) % cpp : 0;
    if (int'(col) != ec || int'(line) != el) begin
      if (e_pos == 0) begin a_pos = int'(line) * 4096 + int'(col); x_pos = el * 4096 + ec; end
      e_pos++;
    end
    if (int'(hs_n) != xh) begin if (e_hs == 0) begin a_hs = hs_n; x_hs = xh; end e_hs++; end
    if (int'(vs_n) != xv) begin if (e_vs == 0) begin a_vs = vs_n; x_vs = xv; end e_vs++; end
    if (int'(de) != xd)   begin if (e_de == 0) begin a_de = de;   x_de = xd; end e_de++; end
    if (int'(ph) != xp)   begin if (e_ph == 0) begin a_ph = ph;   x_ph = xp; end e_ph++; end
  endtask

  task automatic report(string tag);
    check({tag, " R2 R5 position(line*4096+col)"}, e_pos ? a_pos : 0, e_pos ? x_pos : 0);
    check({tag, " R3 hsync"}, e_hs ? a_hs : 0, e_hs ? x_hs : 0);
    check({tag, " R5 vsync"}, e_vs ? a_vs : 0, e_vs ? x_vs : 0);
    check({tag, " R4 R6 de"}, e_de ? a_de : 0, e_de ? x_de : 0);
    check({tag, " R1 phase"}, e_ph ? a_ph : 0, e_ph ? x_ph : 0);
  endtask

  task automatic step(int n, int switch_at, logic new_fmt);
    for (int i = 0; i < n; i++) begin
      logic f;
      if (i == switch_at) fmt = new_fmt;
      f = fmt;
      @(posedge clk); #1;
      ec++;
      if (ec == 336 * cpp) begin
        ec = 0; el++;
        if (el == VL) el = 0;
      end
      if (ec == 0 && el == 0) cpp = cpp_of(f);
      compare_now();
    end
  endtask

  task automatic start(logic f);
    fmt = f; en = 1'b1;
    @(posedge clk); #1;
    ec = 0; el = 0; cpp = cpp_of(f);
    compare_now();
  endtask

  task automatic stop();
    en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R9 hsync in reset", hs_n, 1);
    check("R9 vsync in reset", vs_n, 1);
    check("R9 de in reset", de, 0);
    check("R9 counters in reset", int'(col) + int'(line) + int'(ph), 0);
  endtask

  task automatic t_rgb16();
    clear_errs();
    start(1'b0);
    step(VL * 672 + 100, -1, 1'b0);
    report("rgb16");
    stop();
  endtask

  task automatic t_rgb24();
    clear_errs();
    start(1'b1);
    step(VL * 1008 + 100, -1, 1'b1);
    report("rgb24");
    stop();
  endtask

  task automatic t_fmt_switch();
    clear_errs();
    start(1'b1);
    step(VL * 1008 + VL * 672 + 200, 5 * 1008 + 40, 1'b0);
    report("R7 fmt switch");
    check("R7 line length after switch (col wrap)", cpp, 2);
  endtask

  task automatic t_disable();
    step(1008 + 30, -1, 1'b0);
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check("R8 col/line/phase cleared", int'(col) + int'(line) + int'(ph), 0);
      check("R8 syncs inactive, de low", {hs_n, vs_n, de}, 3'b110);
    end
    clear_errs();
    start(1'b1);
    step(2 * 1008, -1, 1'b1);
    report("R8 restart");
    stop();
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_rgb16();
    t_rgb24();
    t_fmt_switch();
    t_disable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule